// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer

This block takes a single-data-rate SDRAM from power-on to normal operation, then keeps it refreshed. After reset it holds the command bus at NOP for a programmable settling time. It then closes every bank with one precharge-all and issues a programmable number of auto-refresh commands. Next it writes the mode register, with the CAS latency and burst-length code placed directly on the SDRAM address pins. After a guard time it raises `mem_ready`. From then on an interval timer requests one auto-refresh each time it expires.

The timing inputs are counts in clocks. They are expected to stay steady while reset is released and the sequence runs. Values below the device minimum are raised to that minimum: 2 clocks for precharge and refresh spacing, 3 clocks for the mode guard, and 1 for the startup refresh count. Every output pin is registered. All spacings below are measured between the cycles in which the commands appear on the pins. Command codes are written as {cs_n, ras_n, cas_n, we_n}.

The states, in sequence order, are:
- BOOT: loads the settling count.
- PWRUP: the settling wait.
- PRECH: issues the precharge-all.
- WAIT_RP: the precharge wait.
- INIT_REF: issues a startup refresh.
- WAIT_RC: the refresh wait. It loops back to INIT_REF while startup refreshes remain, and otherwise goes to LOAD_MODE.
- LOAD_MODE: issues the mode write.
- WAIT_MRD: the mode guard, after which the block moves to RUN.
- RUN: ready and idle. It goes to RUN_REF when a refresh request is pending.
- RUN_REF: issues a periodic refresh.
- RUN_RC: the refresh wait. It goes back to RUN_REF if a request is pending when the wait ends, and otherwise back to RUN.

An asynchronous reset returns the block to BOOT from any state.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_n is low, mem_ready is 0 and the command pins carry NOP (0111). sdr_cke is 1 at all times.
- R2: After reset is released, only NOP appears until the precharge-all. The precharge-all comes no earlier than cfg_pwrup_wait clocks and no later than cfg_pwrup_wait+4 clocks after release.
- R3: Precharge-all is code 0010, with address bit 10 high, all other address bits 0 and bank 0.
- R4: The first startup auto-refresh (code 0001) appears exactly max(cfg_trp,2) clocks after the precharge-all.
- R5: Exactly max(cfg_init_refs,1) startup auto-refreshes are issued, consecutive ones exactly max(cfg_trc,2) clocks apart.
- R6: The mode write (code 0000) appears exactly max(cfg_trc,2) clocks after the last startup refresh. Its bank is 0 and its address is {0..., cfg_cas_lat at bits 6:4, 0 at bit 3, cfg_burst_code at bits 2:0}.
- R7: mem_ready rises exactly max(cfg_tmrd,3) clocks after the mode write, with only NOPs between the two. It then stays high until reset.
- R8: The first periodic auto-refresh appears cfg_ref_interval+1 clocks after mem_ready rises. Later ones follow every cfg_ref_interval clocks, provided that interval exceeds max(cfg_trc,2).
- R9: A refresh request raised while the previous refresh's spacing window is still open is held, not dropped. It is issued as soon as the window closes, exactly max(cfg_trc,2) clocks after the previous refresh.
- R11: Asserting reset while mem_ready is high clears mem_ready at once. The full sequence then restarts from the settling wait.
- R12: While mem_ready is high, only NOP and auto-refresh appear on the command pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pwrup_wait | input | WAIT_W | Settling time in clocks before precharge-all |
| cfg_trp | input | TIME_W | Precharge-to-refresh spacing in clocks |
| cfg_trc | input | TIME_W | Refresh-to-command spacing in clocks |
| cfg_tmrd | input | TIME_W | Mode write to ready spacing in clocks |
| cfg_init_refs | input | REFS_W | Number of startup auto-refreshes |
| cfg_cas_lat | input | 3 | CAS latency code for the mode word |
| cfg_burst_code | input | 3 | Burst-length code for the mode word |
| cfg_ref_interval | input | IVL_W | Periodic refresh interval in clocks |
| sdr_cke | output | 1 | Clock enable, held high |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_ba | output | BANK_W | Bank address |
| sdr_addr | output | ADDR_W | Row/mode address |
| mem_ready | output | 1 | Normal accesses may begin |

## Verification
The sequence is run with several timing sets:
- Nominal parts: a 100 µs settling time, eight startup refreshes and a 0x2E0 interval.
- Stretched spacings: two startup refreshes and a nonzero mode word.
- Below-minimum values: these must be raised to 2, 2, 3 and one refresh.
- A refresh interval shorter than the refresh spacing.

Each run checks the exact clock gap between every pair of commands, so a timer off by one or a clamp that is missing shows up as a wrong gap. The short-interval run tells a held request, which arrives one spacing later, apart from a dropped one, which arrives a whole interval later. A reset in the middle of operation shows that ready falls at once and that the sequence restarts cleanly.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Sequencer states.
    typedef enum logic [3:0] {
        ST_BOOT,
        ST_PWRUP,
        ST_PRECH,
        ST_WAIT_RP,
        ST_INIT_REF,
        ST_WAIT_RC,
        ST_LOAD_MODE,
        ST_WAIT_MRD,
        ST_RUN,
        ST_RUN_REF,
        ST_RUN_RC
    } seq_state_e;

    // Address source selection for the command driver.
    typedef enum logic [1:0] {
        ADR_ZERO,
        ADR_A10,
        ADR_MODE
    } addr_sel_e;

    // Command codes as {cs_n, ras_n, cas_n, we_n}.
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_PRECH = 4'b0010;
    localparam logic [3:0] CMD_AREF  = 4'b0001;
    localparam logic [3:0] CMD_LMODE = 4'b0000;

    localparam int MODE_W  = 11;
    localparam int A10_BIT = 10;

    // Mode word: burst code [2:0], sequential order [3]=0, CAS [6:4], rest 0.
    function automatic logic [MODE_W-1:0] build_mode(input logic [2:0] cas,
                                                     input logic [2:0] burst);
        build_mode = {4'b0000, cas, 1'b0, burst};
    endfunction

endpackage

// File: rtl/sdr_wait_counter.sv
module sdr_wait_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         ack,
    input  logic [W-1:0] interval,
    output logic         pend
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] tmr_q;
    logic         pend_q;
    logic         expire;

    assign expire = en && (tmr_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (!en || expire) begin
            tmr_q <= interval - ONE;
        end else begin
            tmr_q <= tmr_q - ONE;
        end
    end

    // A new expiry wins over an acknowledge in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!en) begin
            pend_q <= 1'b0;
        end else if (expire) begin
            pend_q <= 1'b1;
        end else if (ack) begin
            pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_code,
    input  addr_sel_e         addr_sel,
    input  logic [MODE_W-1:0] mode_bits,
    input  logic              run_flag,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);

    logic [ADDR_W-1:0] addr_nx;

    always_comb begin
        addr_nx = '0;
        case (addr_sel)
            ADR_A10:  addr_nx[A10_BIT] = 1'b1;
            ADR_MODE: addr_nx[MODE_W-1:0] = mode_bits;
            default:  addr_nx = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            ba    <= '0;
            addr  <= '0;
            ready <= 1'b0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= cmd_code;
            ba    <= '0;
            addr  <= addr_nx;
            ready <= run_flag;
        end
    end

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int WAIT_W = 16,
    parameter int REFS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_done,
    input  logic              ref_pend,
    input  logic [WAIT_W-1:0] pw_val,
    input  logic [WAIT_W-1:0] rp_val,
    input  logic [WAIT_W-1:0] rc_val,
    input  logic [WAIT_W-1:0] mrd_val,
    input  logic [REFS_W-1:0] refs_eff,
    output logic              cnt_load,
    output logic [WAIT_W-1:0] cnt_val,
    output logic [3:0]        cmd_code,
    output addr_sel_e         addr_sel,
    output logic              run_flag,
    output logic              ref_ack
);

    localparam logic [REFS_W-1:0] ONE_REF = REFS_W'(1);

    seq_state_e        state_q, state_nx;
    logic [REFS_W-1:0] refs_left_q;

    // State register and startup refresh budget.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_BOOT;
            refs_left_q <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_PRECH) begin
                refs_left_q <= refs_eff;
            end else if (state_q == ST_INIT_REF) begin
                refs_left_q <= refs_left_q - ONE_REF;
            end
        end
    end

    // Transitions.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_BOOT:      state_nx = ST_PWRUP;
            ST_PWRUP:     if (cnt_done) state_nx = ST_PRECH;
            ST_PRECH:     state_nx = ST_WAIT_RP;
            ST_WAIT_RP:   if (cnt_done) state_nx = ST_INIT_REF;
            ST_INIT_REF:  state_nx = ST_WAIT_RC;
            ST_WAIT_RC:   if (cnt_done) state_nx = (refs_left_q == '0) ? ST_LOAD_MODE : ST_INIT_REF;
            ST_LOAD_MODE: state_nx = ST_WAIT_MRD;
            ST_WAIT_MRD:  if (cnt_done) state_nx = ST_RUN;
            ST_RUN:       if (ref_pend) state_nx = ST_RUN_REF;
            ST_RUN_REF:   state_nx = ST_RUN_RC;
            ST_RUN_RC:    if (cnt_done) state_nx = ref_pend ? ST_RUN_REF : ST_RUN;
            default:      state_nx = ST_BOOT;
        endcase
    end

    // Outputs.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        cmd_code = CMD_NOP;
        addr_sel = ADR_ZERO;
        run_flag = 1'b0;
        ref_ack  = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                cnt_load = 1'b1;
                cnt_val  = pw_val;
            end
            ST_PRECH: begin
                cmd_code = CMD_PRECH;
                addr_sel = ADR_A10;
                cnt_load = 1'b1;
                cnt_val  = rp_val;
            end
            ST_INIT_REF: begin
                cmd_code = CMD_AREF;
                cnt_load = 1'b1;
                cnt_val  = rc_val;
            end
            ST_LOAD_MODE: begin
                cmd_code = CMD_LMODE;
                addr_sel = ADR_MODE;
                cnt_load = 1'b1;
                cnt_val  = mrd_val;
            end
            ST_RUN: run_flag = 1'b1;
            ST_RUN_REF: begin
                run_flag = 1'b1;
                cmd_code = CMD_AREF;
                cnt_load = 1'b1;
                cnt_val  = rc_val;
                ref_ack  = 1'b1;
            end
            ST_RUN_RC: run_flag = 1'b1;
            ST_PWRUP, ST_WAIT_RP, ST_WAIT_RC, ST_WAIT_MRD: begin
                cmd_code = CMD_NOP;
            end
            default: cmd_code = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int WAIT_W = 16,
    parameter int TIME_W = 4,
    parameter int REFS_W = 4,
    parameter int IVL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] cfg_pwrup_wait,
    input  logic [TIME_W-1:0] cfg_trp,
    input  logic [TIME_W-1:0] cfg_trc,
    input  logic [TIME_W-1:0] cfg_tmrd,
    input  logic [REFS_W-1:0] cfg_init_refs,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [2:0]        cfg_burst_code,
    input  logic [IVL_W-1:0]  cfg_ref_interval,
    output logic              sdr_cke,
    output logic              sdr_cs_n,
    output logic              sdr_ras_n,
    output logic              sdr_cas_n,
    output logic              sdr_we_n,
    output logic [BANK_W-1:0] sdr_ba,
    output logic [ADDR_W-1:0] sdr_addr,
    output logic              mem_ready
);

    localparam logic [WAIT_W-1:0] GAP_MIN = WAIT_W'(2);
    localparam logic [WAIT_W-1:0] MRD_MIN = WAIT_W'(3);
    localparam logic [REFS_W-1:0] REF_MIN = REFS_W'(1);
    localparam logic [IVL_W-1:0]  IVL_MIN = IVL_W'(1);

    logic [WAIT_W-1:0] trp_w, trc_w, mrd_w;
    logic [WAIT_W-1:0] trp_eff, trc_eff, mrd_eff;
    logic [WAIT_W-1:0] rp_val, rc_val, mrd_val;
    logic [REFS_W-1:0] refs_eff;
    logic [IVL_W-1:0]  ivl_eff;
    logic [MODE_W-1:0] mode_bits;

    logic              cnt_load, cnt_done;
    logic [WAIT_W-1:0] cnt_val;
    logic              ref_pend, ref_ack, run_flag;
    logic [3:0]        cmd_code;
    addr_sel_e         addr_sel;

    // Raise timing values to the device minimums; waits count gap minus the issue cycle minus one.
    assign trp_w    = WAIT_W'(cfg_trp);
    assign trc_w    = WAIT_W'(cfg_trc);
    assign mrd_w    = WAIT_W'(cfg_tmrd);
    assign trp_eff  = (trp_w < GAP_MIN) ? GAP_MIN : trp_w;
    assign trc_eff  = (trc_w < GAP_MIN) ? GAP_MIN : trc_w;
    assign mrd_eff  = (mrd_w < MRD_MIN) ? MRD_MIN : mrd_w;
    assign rp_val   = trp_eff - GAP_MIN;
    assign rc_val   = trc_eff - GAP_MIN;
    assign mrd_val  = mrd_eff - GAP_MIN;
    assign refs_eff = (cfg_init_refs == '0) ? REF_MIN : cfg_init_refs;
    assign ivl_eff  = (cfg_ref_interval == '0) ? IVL_MIN : cfg_ref_interval;
    assign mode_bits = build_mode(cfg_cas_lat, cfg_burst_code);

    assign sdr_cke = 1'b1;

    sdr_init_fsm #(
        .WAIT_W (WAIT_W),
        .REFS_W (REFS_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_done (cnt_done),
        .ref_pend (ref_pend),
        .pw_val   (cfg_pwrup_wait),
        .rp_val   (rp_val),
        .rc_val   (rc_val),
        .mrd_val  (mrd_val),
        .refs_eff (refs_eff),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .cmd_code (cmd_code),
        .addr_sel (addr_sel),
        .run_flag (run_flag),
        .ref_ack  (ref_ack)
    );

    sdr_wait_counter #(
        .W (WAIT_W)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    sdr_refresh_timer #(
        .W (IVL_W)
    ) u_rtmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_flag),
        .ack      (ref_ack),
        .interval (ivl_eff),
        .pend     (ref_pend)
    );

    sdr_cmd_drive #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_code  (cmd_code),
        .addr_sel  (addr_sel),
        .mode_bits (mode_bits),
        .run_flag  (run_flag),
        .cs_n      (sdr_cs_n),
        .ras_n     (sdr_ras_n),
        .cas_n     (sdr_cas_n),
        .we_n      (sdr_we_n),
        .ba        (sdr_ba),
        .addr      (sdr_addr),
        .ready     (mem_ready)
    );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sdr_cs_n,
    input logic              sdr_ras_n,
    input logic              sdr_cas_n,
    input logic              sdr_we_n,
    input logic [BANK_W-1:0] sdr_ba,
    input logic [ADDR_W-1:0] sdr_addr,
    input logic              mem_ready
);

    logic [3:0] cmd;
    assign cmd = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};

    // R1: ready held low while reset is applied.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_ready_low_in_reset: assert (!mem_ready);
        end
    end

    // R3: precharge closes all banks.
    a_r3_prech_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> sdr_addr[10]);

    // R5: every refresh is followed by a NOP.
    a_r5_ref_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0001) |=> (cmd == 4'b0111));

    // R6: mode write targets bank 0.
    a_r6_mode_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (sdr_ba == '0));

    // R7: ready stays up once raised.
    a_r7_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |=> mem_ready);

    // R7: ready rises on a NOP cycle.
    a_r7_ready_rises_on_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ready) |-> (cmd == 4'b0111));

    // R12: only NOP and refresh once ready.
    a_r12_run_cmds_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> ((cmd == 4'b0111) || (cmd == 4'b0001)));

    // R2: only the four defined codes appear.
    a_r2_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0111) || (cmd == 4'b0010) || (cmd == 4'b0001) || (cmd == 4'b0000));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdr_cs_n  (sdr_cs_n),
    .sdr_ras_n (sdr_ras_n),
    .sdr_cas_n (sdr_cas_n),
    .sdr_we_n  (sdr_we_n),
    .sdr_ba    (sdr_ba),
    .sdr_addr  (sdr_addr),
    .mem_ready (mem_ready)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

    localparam int ADDR_W = 12;
    localparam int BANK_W = 2;
    localparam int WAIT_W = 16;
    localparam int TIME_W = 4;
    localparam int REFS_W = 4;
    localparam int IVL_W  = 16;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [WAIT_W-1:0] cfg_pwrup_wait;
    logic [TIME_W-1:0] cfg_trp, cfg_trc, cfg_tmrd;
    logic [REFS_W-1:0] cfg_init_refs;
    logic [2:0]        cfg_cas_lat, cfg_burst_code;
    logic [IVL_W-1:0]  cfg_ref_interval;
    logic              sdr_cke, sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n;
    logic [BANK_W-1:0] sdr_ba;
    logic [ADDR_W-1:0] sdr_addr;
    logic              mem_ready;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .ADDR_W (ADDR_W), .BANK_W (BANK_W), .WAIT_W (WAIT_W),
        .TIME_W (TIME_W), .REFS_W (REFS_W), .IVL_W (IVL_W)
    ) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_pwrup_wait   (cfg_pwrup_wait),
        .cfg_trp          (cfg_trp),
        .cfg_trc          (cfg_trc),
        .cfg_tmrd         (cfg_tmrd),
        .cfg_init_refs    (cfg_init_refs),
        .cfg_cas_lat      (cfg_cas_lat),
        .cfg_burst_code   (cfg_burst_code),
        .cfg_ref_interval (cfg_ref_interval),
        .sdr_cke          (sdr_cke),
        .sdr_cs_n         (sdr_cs_n),
        .sdr_ras_n        (sdr_ras_n),
        .sdr_cas_n        (sdr_cas_n),
        .sdr_we_n         (sdr_we_n),
        .sdr_ba           (sdr_ba),
        .sdr_addr         (sdr_addr),
        .mem_ready        (mem_ready)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Event monitor, sampled away from the active edge.
    int          cyc, ev_n, nop_pre, early_bad, rdy_rise, bad_after_rdy;
    bit          pre_seen, rdy_q;
    logic [3:0]  ev_cmd  [64];
    int          ev_cyc  [64];
    int          ev_addr [64];
    int          ev_ba   [64];
    logic [3:0]  mcmd;

    always @(negedge clk) begin
        mcmd = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};
        if (!rst_n) begin
            cyc = 0; ev_n = 0; nop_pre = 0; early_bad = 0; rdy_rise = -1;
            bad_after_rdy = 0; pre_seen = 1'b0; rdy_q = 1'b0;
        end else begin
            cyc++;
            if (!pre_seen) begin
                if (mcmd == C_NOP) nop_pre++;
                else if (mcmd != C_PRE) early_bad++;
            end
            if (mcmd == C_PRE) pre_seen = 1'b1;
            if (mcmd != C_NOP && ev_n < 64) begin
                ev_cmd[ev_n]  = mcmd;
                ev_cyc[ev_n]  = cyc;
                ev_addr[ev_n] = int'(sdr_addr);
                ev_ba[ev_n]   = int'(sdr_ba);
                ev_n++;
            end
            if (mem_ready && !rdy_q) rdy_rise = cyc;
            if (mem_ready && (mcmd == C_PRE || mcmd == C_LMR)) bad_after_rdy++;
            rdy_q = mem_ready;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic set_cfg(input int pw, input int trp, input int trc, input int mrd,
                           input int refs, input int cas, input int bl, input int ivl);
        cfg_pwrup_wait   = WAIT_W'(pw);
        cfg_trp          = TIME_W'(trp);
        cfg_trc          = TIME_W'(trc);
        cfg_tmrd         = TIME_W'(mrd);
        cfg_init_refs    = REFS_W'(refs);
        cfg_cas_lat      = 3'(cas);
        cfg_burst_code   = 3'(bl);
        cfg_ref_interval = IVL_W'(ivl);
    endtask

    task automatic pulse_reset();
        @(posedge clk); #2;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    // Runs a full bring-up and checks every gap; tag names the scenario.
    task automatic run_sequence(input string tag, input int pw, input int trp, input int trc,
                                input int mrd, input int refs, input int cas, input int bl,
                                input int ivl, input int first_gap, input int next_gap,
                                input string next_req);
        int trp_e, trc_e, mrd_e, refs_e, lm, need, k;
        trp_e  = (trp < 2) ? 2 : trp;
        trc_e  = (trc < 2) ? 2 : trc;
        mrd_e  = (mrd < 3) ? 3 : mrd;
        refs_e = (refs < 1) ? 1 : refs;
        lm     = refs_e + 1;
        need   = refs_e + 4;
        set_cfg(pw, trp, trc, mrd, refs, cas, bl, ivl);
        pulse_reset();
        k = 0;
        while (ev_n < need && k < 40000) begin
            @(posedge clk);
            k++;
        end
        #2;
        check({tag, " R2 event count"}, (ev_n >= need) ? 1 : 0, 1);
        if (ev_n < need) return;
        // R2 settling and quiet bus
        check_range({tag, " R2 nops before precharge"}, nop_pre, pw, pw + 4);
        check({tag, " R2 no early command"}, early_bad, 0);
        // R3 precharge-all form
        check({tag, " R3 precharge code"}, int'(ev_cmd[0]), int'(C_PRE));
        check({tag, " R3 precharge address"}, ev_addr[0], 1 << 10);
        check({tag, " R3 precharge bank"}, ev_ba[0], 0);
        // R4, R5 startup refreshes
        for (int i = 1; i <= refs_e; i++) begin
            check({tag, " R5 startup refresh code"}, int'(ev_cmd[i]), int'(C_REF));
            if (i == 1)
                check({tag, " R4 precharge to refresh gap"}, ev_cyc[1] - ev_cyc[0], trp_e);
            else
                check({tag, " R5 refresh spacing"}, ev_cyc[i] - ev_cyc[i-1], trc_e);
        end
        // R6 mode write
        check({tag, " R6 mode code"}, int'(ev_cmd[lm]), int'(C_LMR));
        check({tag, " R6 refresh to mode gap"}, ev_cyc[lm] - ev_cyc[lm-1], trc_e);
        check({tag, " R6 mode word"}, ev_addr[lm], (cas << 4) | bl);
        check({tag, " R6 mode bank"}, ev_ba[lm], 0);
        // R7 ready
        check({tag, " R7 mode to ready gap"}, rdy_rise - ev_cyc[lm], mrd_e);
        check({tag, " R7 ready still high"}, int'(mem_ready), 1);
        // R8 / R9 periodic refresh
        check({tag, " R8 first periodic code"}, int'(ev_cmd[lm+1]), int'(C_REF));
        check({tag, " R8 ready to first periodic"}, ev_cyc[lm+1] - rdy_rise, first_gap);
        check({tag, " ", next_req, " periodic spacing"}, ev_cyc[lm+2] - ev_cyc[lm+1], next_gap);
        check({tag, " R12 no init command after ready"}, bad_after_rdy, 0);
    endtask

    task automatic t_reset_state();
        set_cfg(20, 2, 5, 3, 8, 2, 0, 100);
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        check("R1 ready in reset", int'(mem_ready), 0);
        check("R1 command in reset", int'({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}), int'(C_NOP));
        check("R1 cke in reset", int'(sdr_cke), 1);
    endtask

    task automatic t_nominal();
        // 100 us at 100 MHz, 8 startup refreshes, interval 0x2E0
        run_sequence("nominal", 10000, 2, 5, 3, 8, 2, 0, 'h2E0, 'h2E0 + 1, 'h2E0, "R8");
        check("R1 cke while running", int'(sdr_cke), 1);
    endtask

    task automatic t_stretched();
        run_sequence("stretched", 50, 3, 7, 5, 2, 3, 3, 40, 41, 40, "R8");
    endtask

    task automatic t_clamped();
        run_sequence("clamped", 5, 0, 1, 0, 0, 2, 0, 20, 21, 20, "R8");
    endtask

    task automatic t_held_request();
        run_sequence("held", 12, 2, 8, 3, 2, 2, 0, 6, 7, 8, "R9");
    endtask

    task automatic t_mid_reset();
        check("R11 ready before reset", int'(mem_ready), 1);
        @(posedge clk); #2;
        rst_n = 1'b0;
        #1;
        check("R11 ready drops at once", int'(mem_ready), 0);
        check("R11 bus NOP at reset", int'({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}), int'(C_NOP));
        run_sequence("R11 restart", 30, 2, 4, 4, 3, 2, 1, 30, 31, 30, "R8");
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=%0d cycles expected<=150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        set_cfg(20, 2, 5, 3, 8, 2, 0, 100);
        t_reset_state();
        t_nominal();
        t_stretched();
        t_clamped();
        t_held_request();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule